// File: doc/BRIEF.md
# Latched Status-Change Interrupt Unit

This block watches a small set of external status lines (carrier, clear-to-send, sync/hunt, break and similar) together with an internal transmit underrun/end-of-message latch. When an enabled line changes, the block takes a snapshot of every line and raises a level interrupt. The snapshot stays frozen while the interrupt is pending, so a pulse too short for software to see directly stays visible in the status read port.

Software acknowledges by pulsing a reset-status command strobe. At release the block compares the live lines with the frozen snapshot. If an enabled line still differs, it takes a new snapshot and the interrupt stays asserted. If the line changed and then went back before the release, nothing is raised.

The underrun/end-of-message latch is set by the transmitter. A reset command clears it only while the transmitter is enabled. If that reset arrives while the transmitter is disabled, the latch stays set. The block still raises a status interrupt whose snapshot shows the bit clear, provided no interrupt is pending or a reset-status strobe arrives in the same cycle.

Top module: `stat_latch_irq`

## Requirements
- R1: After reset, `irq` is 0, `stat_rd` is all zeros and the underrun latch is clear.
- R2: A change on an enabled `stat_in` bit goes through two synchronizer flops. `irq` rises on the third rising edge after the change. `stat_rd[W-1:0]` then holds the synchronized value of every input and `stat_rd[W]` holds the underrun latch.
- R3: While no interrupt is pending, a change on a bit whose `stat_en` bit is 0 raises no interrupt, and `stat_rd` follows the live values one cycle behind the synchronizer.
- R4: While `irq` is 1 and `clr_stb` is 0, `stat_rd` does not change, whatever the inputs do. A one-cycle input pulse therefore stays readable.
- R5: Once `irq` is 1, it stays 1 until a cycle in which `clr_stb` is 1.
- R6: A `clr_stb` cycle in which the live lines equal the snapshot on every enabled bit makes `irq` 0 on the next edge. After that, `stat_rd` follows the live values.
- R7: A `clr_stb` cycle in which any enabled live bit differs from the snapshot keeps `irq` at 1 and reloads `stat_rd` with the live values on the same edge. A reset and a change in one cycle therefore resolve as release first, then evaluation.
- R8: A second change that returns to its earlier level before `clr_stb` raises no further interrupt.
- R9: `und_set` sets the underrun latch, which is `stat_rd[W]` and mask bit `stat_en[W]`. `und_clr` together with `tx_en`=1 clears it. Set wins if both arrive in the same cycle.
- R10: `und_clr` with `tx_en`=0 leaves the latch set. If no interrupt is pending, or `clr_stb` arrives in the same cycle, it raises `irq` with `stat_rd[W]` shown as 0, whatever the mask holds.
- R11: `und_clr` with `tx_en`=0 while an interrupt is pending and `clr_stb` is 0 has no effect on `irq` or `stat_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_in | input | W | Raw asynchronous status lines |
| stat_en | input | W+1 | Per-bit change interrupt enable; bit W is the underrun latch |
| clr_stb | input | 1 | Reset-status command strobe, one cycle |
| und_set | input | 1 | Sets the underrun/end-of-message latch |
| und_clr | input | 1 | Reset-underrun command strobe |
| tx_en | input | 1 | Transmitter enabled |
| stat_rd | output | W+1 | Status snapshot (underrun latch in bit W) |
| irq | output | 1 | Status-change interrupt request, level |

## Verification
The reset-status strobe and a status change can arrive in the same cycle. So can the reset-status strobe and a reset-underrun command issued with the transmitter off. The bench provokes the first case by changing a line while an interrupt is pending, and also with a pulse that has already ended before the release. It then checks that `irq` stays high on a persisting change and drops when the line has returned. For the second case it issues both strobes in one cycle. It judges the result by `irq` staying high and by the snapshot bit for the latch reading 0 while the latch itself stays set, which shows after a later release.

// File: rtl/stat_latch_irq.sv
module stat_latch_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_in,
  input  logic [W:0]   stat_en,
  input  logic         clr_stb,
  input  logic         und_set,
  input  logic         und_clr,
  input  logic         tx_en,
  output logic [W:0]   stat_rd,
  output logic         irq
);
  localparam int NB = W + 1;

  logic [W-1:0]  s1, s2;
  logic          und_q;
  logic [NB-1:0] snap;
  logic          irq_q;

  wire [NB-1:0] live     = {und_q, s2};
  wire [NB-1:0] diff     = (live ^ snap) & stat_en;
  wire          held     = irq_q & ~clr_stb;
  wire          force_ev = und_clr & ~tx_en & ~held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      und_q <= 1'b0;
      snap  <= '0;
      irq_q <= 1'b0;
    end else begin
      s1 <= stat_in;
      s2 <= s1;
      if (und_set)
        und_q <= 1'b1;
      else if (und_clr && tx_en)
        und_q <= 1'b0;
      if (force_ev) begin
        snap  <= {1'b0, s2};
        irq_q <= 1'b1;
      end else if (!held) begin
        snap  <= live;
        irq_q <= |diff;
      end
    end
  end

  assign stat_rd = snap;
  assign irq     = irq_q;

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr_stb |=> irq_q);
  // R4
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr_stb |=> $stable(stat_rd));
  // R6
  quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb && (diff == '0) && !(und_clr && !tx_en) |=> !irq);
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && (diff == '0) && !und_clr |=> !irq);
  // R9
  und_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_clr && tx_en && !und_set |=> !und_q);
  // R10
  und_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_clr && !tx_en && !held |=> irq && !stat_rd[W]);
endmodule

// File: tb/stat_latch_irq_tb_top.sv
module stat_latch_irq_tb_top;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] stat_in = '0;
  logic [W:0]   stat_en = '0;
  logic clr_stb = 0, und_set = 0, und_clr = 0, tx_en = 1;
  logic [W:0] stat_rd;
  logic irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stat_latch_irq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .stat_en(stat_en),
    .clr_stb(clr_stb), .und_set(und_set), .und_clr(und_clr), .tx_en(tx_en),
    .stat_rd(stat_rd), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_stb = 1; cyc(1); clr_stb = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 irq", irq, 0);
    chk("R1 stat", stat_rd, 0);
    rst_n = 1;
    cyc(2);

    // R2 R3 R6 sweep: every mask on the lines, every bit toggled
    for (int m = 0; m < 16; m++) begin
      for (int b = 0; b < W; b++) begin
        stat_en = {1'b0, 4'(m)};
        stat_in[b] = ~stat_in[b];
        cyc(2);
        chk("R2 no early irq", irq, 0);
        cyc(1);
        chk("R2/R3 irq", irq, (m >> b) & 1);
        chk("R2/R3 stat", stat_rd, {1'b0, stat_in});
        pulse_clr();
        chk("R6 drop", irq, 0);
        chk("R6 stat", stat_rd, {1'b0, stat_in});
      end
    end

    // R4 R5 R7: one-cycle pulse stays visible, release sees the return
    stat_en = 5'h0f; stat_in = 4'h0; cyc(4); pulse_clr(); cyc(1);
    stat_in[0] = 1; cyc(1); stat_in[0] = 0;
    cyc(6);
    chk("R5 held", irq, 1);
    chk("R4 pulse visible", stat_rd, 5'h01);
    pulse_clr();
    chk("R7 reraise", irq, 1);
    chk("R7 reload", stat_rd, 5'h00);
    pulse_clr();
    chk("R6 drop", irq, 0);

    // R8: second change returns before release
    stat_in[1] = 1; cyc(4);
    chk("R2 irq", irq, 1);
    stat_in[2] = 1; cyc(2); stat_in[2] = 0; cyc(4);
    chk("R4 frozen", stat_rd, 5'h02);
    pulse_clr();
    chk("R8 no reraise", irq, 0);

    // R7: second change persists
    stat_in[1] = 0; cyc(4);
    stat_in[3] = 1; cyc(4);
    chk("R4 frozen", stat_rd, 5'h00);
    pulse_clr();
    chk("R7 persist irq", irq, 1);
    chk("R7 persist stat", stat_rd, 5'h08);
    // same cycle: release and change together
    stat_in[3] = 0; clr_stb = 1; cyc(1); clr_stb = 0;
    chk("R7 same cycle", irq, 0);
    cyc(2);
    chk("R7 late change", irq, 1);
    pulse_clr();
    chk("R6 drop", irq, 0);

    // R9: underrun latch set/clear, masked
    stat_en = 5'h0f;
    und_set = 1; cyc(1); und_set = 0; cyc(1);
    chk("R9 set", stat_rd[W], 1);
    chk("R3 masked und", irq, 0);
    tx_en = 1; und_set = 1; und_clr = 1; cyc(1); und_set = 0; und_clr = 0; cyc(1);
    chk("R9 set wins", stat_rd[W], 1);
    und_clr = 1; cyc(1); und_clr = 0; cyc(1);
    chk("R9 clear", stat_rd[W], 0);

    // R10: clear while transmitter off, idle
    und_set = 1; cyc(1); und_set = 0; cyc(1);
    tx_en = 0; und_clr = 1; cyc(1); und_clr = 0;
    chk("R10 irq", irq, 1);
    chk("R10 shown clear", stat_rd[W], 0);
    pulse_clr(); cyc(1);
    chk("R10 latch kept", stat_rd[W], 1);
    chk("R10 drop", irq, 0);

    // R11: pending, no reset-status
    stat_in[0] = 1; cyc(4);
    chk("R2 irq", irq, 1);
    und_clr = 1; cyc(1); und_clr = 0;
    chk("R11 irq", irq, 1);
    chk("R11 stat", stat_rd, 5'h11);
    // R10: same cycle as reset-status
    und_clr = 1; clr_stb = 1; cyc(1); und_clr = 0; clr_stb = 0;
    chk("R10 with clr irq", irq, 1);
    chk("R10 with clr stat", stat_rd, 5'h01);
    pulse_clr();
    chk("R10 drop", irq, 0);
    chk("R10 latch kept", stat_rd[W], 1);

    // R9 R2: enabled underrun bit interrupts when cleared
    tx_en = 1; stat_en = 5'h10;
    und_clr = 1; cyc(1); und_clr = 0; cyc(1);
    chk("R9 enabled irq", irq, 1);
    chk("R9 enabled stat", stat_rd, 5'h01);
    pulse_clr();
    chk("R6 drop", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule